// File: doc/BRIEF.md
# Extended parallel cycle gate

This block sits inside a byte-wide parallel port controller and adds the extended-mode address and data cycles. A host issues register accesses over a simple request/busy interface: offset 0 is the data latch, offset 1 the status register, offset 2 the control register, offset 3 starts an address cycle and offset 4 starts a data cycle. Data cycles may move 1, 2 or 4 bytes per access. Address cycles always move one byte.

A cycle runs only when the control register holds the exact mode pattern for its direction. A cycle that is allowed is split into single-byte transfers on the peripheral side, each with a request/acknowledge handshake. A byte that gets no acknowledge within a bounded wait ends the access and sets a sticky timeout flag. The host reads this flag in bit 0 of status and clears it by writing a one there. While a transfer runs, the host sees busy, and any new request waits until the transfer ends.

Top module: `ext_cycle_gate`

## Requirements
- R1: After reset the control register reads 0xCC, both data latches read 0xFF, the timeout flag is 0, busy is low and no peripheral request is raised.
- R2: A control write stores the written byte with bits 7 and 6 forced to 1. It reads back that way, and `busDirRev` follows bit 5 of the stored value.
- R3: A write to offset 3 or 4 starts peripheral transfers only when (control AND 0x2F) equals 0x04. Otherwise it raises no request and no busy.
- R4: A read of offset 3 or 4 starts transfers only when (control AND 0x2F) equals 0x24. Otherwise it returns all ones over the access width (0xFF, 0xFFFF or 0xFFFFFFFF, upper bits zero) with no request.
- R5: An offset-3 access moves exactly one byte with `perIsAddr` high, whatever its size. An offset-4 access has `perIsAddr` low.
- R6: An offset-4 access moves 1, 2 or 4 bytes for size codes 0, 1 or 2, and size code 3 also moves 4 bytes. Bytes go least significant first, and read bytes are assembled into the matching lanes.
- R7: For each byte, `perReq` stays high with stable data and address flag until an acknowledge is sampled. It is low for exactly one cycle before the next byte.
- R8: A byte acknowledged within TIMEOUT_CYCLES cycles of its request succeeds. If no acknowledge arrives, the access ends, the remaining bytes are skipped, the timeout flag is set, and a read returns the bytes received with the missing lanes as 0xFF.
- R9: A status read returns bits 7..1 of `perStatus` with bit 0 replaced by the timeout flag.
- R10: Writing status with bit 0 set clears the timeout flag. Writing it with bit 0 clear leaves the flag unchanged.
- R11: Busy stays high from the cycle after a cycle-access is accepted until its last byte ends. A request made while busy is taken only after busy falls, and no read response appears while busy.
- R12: An offset-0 write updates the write latch, which drives `perDataOut` while idle. An offset-0 read returns the write latch when control bit 5 is 0, and the last byte received in a read cycle when it is 1.
- R13: A register read, or a refused cycle read, raises `hostRvalid` for one cycle, the cycle after acceptance. Reads of offsets 5 to 7 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request, held until taken while busy is low |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 3 | Register offset |
| hostSize | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| hostWdata | input | 32 | Write data, least significant byte first |
| hostBusy | output | 1 | Transfer in progress; requests are not taken |
| hostRvalid | output | 1 | Read data valid, one cycle |
| hostRdata | output | 32 | Read data |
| ctrlOut | output | 8 | Stored control register |
| busDirRev | output | 1 | Data bus reversed (peripheral drives) |
| perReq | output | 1 | Byte transfer request |
| perWrite | output | 1 | Current transfer direction, 1 = to peripheral |
| perIsAddr | output | 1 | Current transfer is an address cycle |
| perDataOut | output | 8 | Byte to peripheral, or write latch when idle |
| perDataIn | input | 8 | Byte from peripheral, taken with the acknowledge |
| perAck | input | 1 | Byte acknowledge |
| perStatus | input | 8 | Peripheral status lines |

## Verification
A register read responds one cycle after it is accepted. The bench therefore samples at the first falling edge after the accepting rising edge and checks that the latency counter is exactly one. For a cycle access, busy rises in the cycle after acceptance. With an acknowledge delay of d cycles, each byte takes d+1 request cycles plus one gap cycle between bytes, so four bytes at d=3 hold busy for exactly 19 cycles, and the bench counts this. The peripheral model drives the acknowledge on falling edges and logs each byte as it acknowledges it. A read response is due in the cycle after the last acknowledge or after the timeout cycle, which is the first falling edge where busy is low.

// File: rtl/ext_cycle_gate_pkg.sv
package ext_cycle_gate_pkg;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_ACYC = 3'd3;
  localparam logic [2:0] OFF_DCYC = 3'd4;

  localparam logic [7:0] MODE_MASK  = 8'h2F;
  localparam logic [7:0] MODE_WR    = 8'h04;
  localparam logic [7:0] MODE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] CTRL_RST   = 8'hCC;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } xferState_t;

  typedef struct packed {
    logic ldData;
    logic ldCtrl;
    logic clrTmo;
    logic setTmo;
    logic loadXfer;
    logic capture;
    logic latchRd;
    logic respond;
    logic drive;
  } dpStrobe_t;

endpackage

// File: rtl/ext_cycle_gate_ctl.sv
module ext_cycle_gate_ctl
  import ext_cycle_gate_pkg::*;
#(
  parameter int HOST_BYTES     = 4,
  parameter int TIMEOUT_CYCLES = 16,
  parameter int IDX_W          = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReq,
  input  logic             hostWrite,
  input  logic [2:0]       hostAddr,
  input  logic [1:0]       hostSize,
  input  logic             statClrBit,
  input  logic             gateWr,
  input  logic             gateRd,
  input  logic             perAck,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] byteIdx,
  output logic             busy,
  output logic             perReq,
  output logic             perWrite,
  output logic             perIsAddr
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  xferState_t       state;
  logic [IDX_W-1:0] idxReg;
  logic [IDX_W-1:0] lastIdx;
  logic [TMR_W-1:0] timer;
  logic             xferWrite;
  logic             xferIsAddr;

  logic accept, isCyc, go, finishOk, failNow;
  logic [IDX_W-1:0] lastIdxNext;

  function automatic logic [IDX_W-1:0] lastFor(input logic [1:0] sz, input logic single);
    int n;
    n = single ? 1 : (1 << sz);
    if (n > HOST_BYTES) n = HOST_BYTES;
    return IDX_W'(n - 1);
  endfunction

  always_comb begin
    accept      = hostReq && (state == ST_IDLE);
    isCyc       = (hostAddr == OFF_ACYC) || (hostAddr == OFF_DCYC);
    go          = accept && isCyc && (hostWrite ? gateWr : gateRd);
    lastIdxNext = lastFor(hostSize, hostAddr == OFF_ACYC);
    finishOk    = (state == ST_XFER) && perAck && (idxReg == lastIdx);
    failNow     = (state == ST_XFER) && !perAck && (timer == TMR_LAST);

    strobe          = '0;
    strobe.ldData   = accept && hostWrite && (hostAddr == OFF_DATA);
    strobe.ldCtrl   = accept && hostWrite && (hostAddr == OFF_CTRL);
    strobe.clrTmo   = accept && hostWrite && (hostAddr == OFF_STAT) && statClrBit;
    strobe.setTmo   = failNow;
    strobe.loadXfer = go;
    strobe.capture  = (state == ST_XFER) && perAck && !xferWrite;
    strobe.latchRd  = accept && !hostWrite && !go;
    strobe.respond  = strobe.latchRd || ((finishOk || failNow) && !xferWrite);
    strobe.drive    = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      idxReg     <= '0;
      lastIdx    <= '0;
      timer      <= '0;
      xferWrite  <= 1'b0;
      xferIsAddr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            state      <= ST_XFER;
            idxReg     <= '0;
            lastIdx    <= lastIdxNext;
            timer      <= '0;
            xferWrite  <= hostWrite;
            xferIsAddr <= (hostAddr == OFF_ACYC);
          end
        end
        ST_XFER: begin
          if (perAck) begin
            timer <= '0;
            if (idxReg == lastIdx) begin
              state <= ST_IDLE;
            end else begin
              state  <= ST_GAP;
              idxReg <= idxReg + 1'b1;
            end
          end else if (timer == TMR_LAST) begin
            state <= ST_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_GAP:  state <= ST_XFER;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign byteIdx   = idxReg;
  assign busy      = (state != ST_IDLE);
  assign perReq    = (state == ST_XFER);
  assign perWrite  = xferWrite;
  assign perIsAddr = xferIsAddr;

endmodule

// File: rtl/ext_cycle_gate_dp.sv
module ext_cycle_gate_dp
  import ext_cycle_gate_pkg::*;
#(
  parameter int HOST_BYTES = 4,
  parameter int IDX_W      = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [IDX_W-1:0]        byteIdx,
  input  logic [2:0]              hostAddr,
  input  logic [1:0]              hostSize,
  input  logic [HOST_BYTES*8-1:0] hostWdata,
  input  logic [7:0]              perDataIn,
  input  logic [7:0]              perStatus,
  output logic                    gateWr,
  output logic                    gateRd,
  output logic [7:0]              ctrlOut,
  output logic [7:0]              perDataOut,
  output logic                    hostRvalid,
  output logic [HOST_BYTES*8-1:0] hostRdata
);

  localparam int HOST_W = HOST_BYTES * 8;

  logic [7:0]        ctrlReg, dataWr, dataRd;
  logic              tmoFlag;
  logic [HOST_W-1:0] shiftReg, rdataReg, rdMux;
  logic              rvalidReg;

  function automatic logic [HOST_W-1:0] onesFor(input logic [1:0] sz, input logic single);
    int n;
    logic [HOST_W-1:0] v;
    n = single ? 1 : (1 << sz);
    if (n > HOST_BYTES) n = HOST_BYTES;
    v = '0;
    for (int b = 0; b < HOST_BYTES; b++) v[b*8 +: 8] = (b < n) ? 8'hFF : 8'h00;
    return v;
  endfunction

  assign gateWr = ((ctrlReg & MODE_MASK) == MODE_WR);
  assign gateRd = ((ctrlReg & MODE_MASK) == MODE_RD);

  always_comb begin
    rdMux = '0;
    case (hostAddr)
      OFF_DATA: rdMux[7:0] = ctrlReg[5] ? dataRd : dataWr;
      OFF_STAT: rdMux[7:0] = {perStatus[7:1], tmoFlag};
      OFF_CTRL: rdMux[7:0] = ctrlReg;
      OFF_DCYC: rdMux      = onesFor(hostSize, 1'b0);
      default:  rdMux[7:0] = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= CTRL_RST;
      dataWr    <= 8'hFF;
      dataRd    <= 8'hFF;
      tmoFlag   <= 1'b0;
      shiftReg  <= '0;
      rdataReg  <= '0;
      rvalidReg <= 1'b0;
    end else begin
      rvalidReg <= strobe.respond;
      if (strobe.ldCtrl) ctrlReg <= hostWdata[7:0] | CTRL_FORCE;
      if (strobe.ldData) dataWr  <= hostWdata[7:0];
      if (strobe.setTmo)      tmoFlag <= 1'b1;
      else if (strobe.clrTmo) tmoFlag <= 1'b0;
      if (strobe.loadXfer) begin
        shiftReg <= hostWdata;
        rdataReg <= onesFor(hostSize, hostAddr == OFF_ACYC);
      end
      if (strobe.latchRd) rdataReg <= rdMux;
      if (strobe.capture) begin
        rdataReg[byteIdx*8 +: 8] <= perDataIn;
        dataRd                   <= perDataIn;
      end
    end
  end

  assign ctrlOut    = ctrlReg;
  assign perDataOut = strobe.drive ? shiftReg[byteIdx*8 +: 8] : dataWr;
  assign hostRvalid = rvalidReg;
  assign hostRdata  = rdataReg;

endmodule

// File: rtl/ext_cycle_gate.sv
module ext_cycle_gate
  import ext_cycle_gate_pkg::*;
#(
  parameter int HOST_BYTES     = 4,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostReq,
  input  logic                    hostWrite,
  input  logic [2:0]              hostAddr,
  input  logic [1:0]              hostSize,
  input  logic [HOST_BYTES*8-1:0] hostWdata,
  output logic                    hostBusy,
  output logic                    hostRvalid,
  output logic [HOST_BYTES*8-1:0] hostRdata,
  output logic [7:0]              ctrlOut,
  output logic                    busDirRev,
  output logic                    perReq,
  output logic                    perWrite,
  output logic                    perIsAddr,
  output logic [7:0]              perDataOut,
  input  logic [7:0]              perDataIn,
  input  logic                    perAck,
  input  logic [7:0]              perStatus
);

  localparam int IDX_W = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1;

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] byteIdx;
  logic             gateWr, gateRd;

  ext_cycle_gate_ctl #(
    .HOST_BYTES(HOST_BYTES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .IDX_W(IDX_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .hostSize(hostSize), .statClrBit(hostWdata[0]),
    .gateWr(gateWr), .gateRd(gateRd), .perAck(perAck),
    .strobe(strobe), .byteIdx(byteIdx), .busy(hostBusy),
    .perReq(perReq), .perWrite(perWrite), .perIsAddr(perIsAddr)
  );

  ext_cycle_gate_dp #(
    .HOST_BYTES(HOST_BYTES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .byteIdx(byteIdx),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .perDataIn(perDataIn), .perStatus(perStatus),
    .gateWr(gateWr), .gateRd(gateRd), .ctrlOut(ctrlOut),
    .perDataOut(perDataOut), .hostRvalid(hostRvalid), .hostRdata(hostRdata)
  );

  assign busDirRev = ctrlOut[5];

endmodule

// File: rtl/ext_cycle_gate_chk.sv
module ext_cycle_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostBusy,
  input logic       hostRvalid,
  input logic [7:0] ctrlOut,
  input logic       perReq,
  input logic       perWrite,
  input logic       perIsAddr,
  input logic [7:0] perDataOut,
  input logic       perAck
);

  // R2
  ctrl_top_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut[7:6] == 2'b11);

  // R3
  gate_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostBusy) |-> ((ctrlOut & 8'h2F) == (perWrite ? 8'h04 : 8'h24)));

  // R7
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    perReq |-> hostBusy);

  // R7
  req_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && $past(perReq) && !$past(perAck)) |-> ($stable(perDataOut) && $stable(perIsAddr)));

  // R11
  no_resp_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> !hostBusy);

  // R11
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostBusy && $past(hostBusy)) |-> $stable(ctrlOut));

endmodule

bind ext_cycle_gate ext_cycle_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .hostBusy(hostBusy), .hostRvalid(hostRvalid),
  .ctrlOut(ctrlOut), .perReq(perReq), .perWrite(perWrite),
  .perIsAddr(perIsAddr), .perDataOut(perDataOut), .perAck(perAck)
);

// File: tb/ext_cycle_gate_bench.sv
module ext_cycle_gate_bench;

  localparam int TO = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWrite = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic        hostBusy, hostRvalid;
  logic [31:0] hostRdata;
  logic [7:0]  ctrlOut, perDataOut;
  logic        busDirRev, perReq, perWrite, perIsAddr;
  logic [7:0]  perDataIn = 8'h00;
  logic        perAck = 1'b0;
  logic [7:0]  perStatus = 8'hA7;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  // peripheral model state
  int ackDelay = 0, stopAt = -1, waitCnt = 0, logCnt = 0;
  logic [7:0] logData [16];
  logic       logAddr [16];
  logic       logWr   [16];

  ext_cycle_gate #(.HOST_BYTES(4), .TIMEOUT_CYCLES(TO)) u_ext_cycle_gate (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostBusy(hostBusy), .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .ctrlOut(ctrlOut), .busDirRev(busDirRev), .perReq(perReq),
    .perWrite(perWrite), .perIsAddr(perIsAddr), .perDataOut(perDataOut),
    .perDataIn(perDataIn), .perAck(perAck), .perStatus(perStatus)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int n);
    return 8'h5A ^ 8'(n * 29);
  endfunction

  always @(negedge clk) begin
    if (perAck) begin
      perAck  = 1'b0;
      waitCnt = 0;
    end else if (perReq) begin
      if (waitCnt == ackDelay && logCnt != stopAt && logCnt < 16) begin
        perAck           = 1'b1;
        perDataIn        = pat(logCnt);
        logData[logCnt]  = perDataOut;
        logAddr[logCnt]  = perIsAddr;
        logWr[logCnt]    = perWrite;
        logCnt++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end else begin
      waitCnt = 0;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearLog(input int d, input int stop);
    ackDelay = d; stopAt = stop; logCnt = 0;
  endtask

  task automatic acc(input logic w, input logic [2:0] a, input logic [1:0] s,
                     input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = w; hostAddr = a; hostSize = s; hostWdata = wd;
    while (hostBusy) @(negedge clk);
    @(negedge clk);
    hostReq = 1'b0;
    lat = 1;
    rd = '0;
    if (!w) begin
      while (!hostRvalid && lat < 200) begin @(negedge clk); lat++; end
      rd = hostRdata;
    end else begin
      while (hostBusy && lat < 200) begin @(negedge clk); lat++; end
    end
  endtask

  function automatic logic [31:0] onesW(int nb);
    return (nb >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ctrlOut == 8'hCC, "R1 ctrl", ctrlOut, 8'hCC);
    chk(!hostBusy && !perReq, "R1 idle", {hostBusy, perReq}, 0);
    chk(perDataOut == 8'hFF, "R1 R12 write latch", perDataOut, 8'hFF);
    acc(0, 3'd2, 0, 0, rd, lat);
    chk(rd == 32'hCC, "R1 ctrl read", rd, 32'hCC);
    chk(lat == 1, "R13 latency", lat, 1);
    acc(0, 3'd0, 0, 0, rd, lat);
    chk(rd == 32'hFF, "R1 data read", rd, 32'hFF);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd == 32'hA6, "R1 R9 status", rd, 32'hA6);
    for (int a = 5; a < 8; a++) begin
      acc(0, 3'(a), 0, 0, rd, lat);
      chk(rd == 32'hFF && lat == 1, "R13 unused offset", rd, 32'hFF);
    end

    // R2 R3 R4 control sweep and gating
    for (int v = 0; v < 64; v++) begin
      logic [7:0] cv;
      logic [31:0] expR;
      cv = 8'(v) ^ ((v & 1) ? 8'h80 : 8'h40);
      acc(1, 3'd2, 0, {24'h0, cv}, rd, lat);
      acc(0, 3'd2, 0, 0, rd, lat);
      chk(rd == {24'h0, cv | 8'hC0}, "R2 ctrl readback", rd, {24'h0, cv | 8'hC0});
      chk(busDirRev == cv[5], "R2 direction", busDirRev, cv[5]);
      clearLog(0, -1);
      acc(1, 3'd4, 0, 32'h3C, rd, lat);
      chk(logCnt == (((cv & 8'h2F) == 8'h04) ? 1 : 0), "R3 write gate", logCnt, 0);
      clearLog(0, -1);
      acc(0, 3'd4, 1, 0, rd, lat);
      expR = ((cv & 8'h2F) == 8'h24) ? {16'h0, pat(1), pat(0)} : 32'h0000_FFFF;
      chk(rd == expR, "R4 read gate", rd, expR);
      chk(logCnt == (((cv & 8'h2F) == 8'h24) ? 2 : 0), "R4 read gate count", logCnt, 0);
    end

    // R5 R6 write cycles
    acc(1, 3'd2, 0, 32'h04, rd, lat);
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 3; d += 2) begin
        int nb;
        logic [31:0] wd;
        nb = (s == 0) ? 1 : (s == 1) ? 2 : 4;
        wd = 32'h8421_C63A ^ 32'(s * 32'h1111_0101 + d);
        clearLog(d, -1);
        acc(1, 3'd4, 2'(s), wd, rd, lat);
        chk(logCnt == nb, "R6 write byte count", logCnt, nb);
        for (int b = 0; b < nb; b++) begin
          chk(logData[b] == wd[b*8 +: 8], "R6 write byte order", logData[b], wd[b*8 +: 8]);
          chk(logAddr[b] == 0 && logWr[b] == 1, "R5 data cycle flags", {logAddr[b], logWr[b]}, 1);
        end
      end
    end
    clearLog(1, -1);
    acc(1, 3'd3, 2'd2, 32'hDEAD_BE77, rd, lat);
    chk(logCnt == 1, "R5 address single byte", logCnt, 1);
    chk(logData[0] == 8'h77 && logAddr[0] == 1, "R5 address byte", {logAddr[0], logData[0]}, 9'h177);

    // R12 write latch
    acc(1, 3'd0, 0, 32'h5A, rd, lat);
    chk(perDataOut == 8'h5A, "R12 latch drives", perDataOut, 8'h5A);
    acc(0, 3'd0, 0, 0, rd, lat);
    chk(rd == 32'h5A, "R12 read dir0", rd, 32'h5A);

    // R6 R5 read cycles
    acc(1, 3'd2, 0, 32'h24, rd, lat);
    for (int s = 0; s < 4; s++) begin
      int nb;
      logic [31:0] expR;
      nb = (s == 0) ? 1 : (s == 1) ? 2 : 4;
      expR = 0;
      for (int b = 0; b < nb; b++) expR[b*8 +: 8] = pat(b);
      clearLog(1, -1);
      acc(0, 3'd4, 2'(s), 0, rd, lat);
      chk(rd == expR, "R6 read assembly", rd, expR);
      chk(logCnt == nb && logAddr[0] == 0 && logWr[0] == 0, "R6 read count", logCnt, nb);
    end
    clearLog(0, -1);
    acc(0, 3'd3, 2'd2, 0, rd, lat);
    chk(rd == {24'h0, pat(0)} && logCnt == 1 && logAddr[0] == 1, "R5 address read", rd, {24'h0, pat(0)});
    acc(0, 3'd0, 0, 0, rd, lat);
    chk(rd == {24'h0, pat(0)}, "R12 read dir1 last byte", rd, {24'h0, pat(0)});

    // R8 timeout boundary
    clearLog(TO - 1, -1);
    acc(0, 3'd4, 0, 0, rd, lat);
    chk(rd == {24'h0, pat(0)}, "R8 late ack ok", rd, {24'h0, pat(0)});
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd[0] == 1'b0, "R8 no flag", rd, 0);
    clearLog(TO, -1);
    acc(0, 3'd4, 0, 0, rd, lat);
    chk(rd == 32'hFF && logCnt == 0, "R8 too late", rd, 32'hFF);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd == 32'hA7, "R8 R9 flag set", rd, 32'hA7);
    acc(1, 3'd1, 0, 32'hFE, rd, lat);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd == 32'hA7, "R10 bit0 clear keeps", rd, 32'hA7);
    acc(1, 3'd1, 0, 32'h01, rd, lat);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd == 32'hA6, "R10 clear", rd, 32'hA6);
    clearLog(0, 2);
    acc(0, 3'd4, 2'd2, 0, rd, lat);
    chk(rd == {16'hFFFF, pat(1), pat(0)}, "R8 partial read", rd, {16'hFFFF, pat(1), pat(0)});
    chk(logCnt == 2, "R8 abandon rest", logCnt, 2);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd[0] == 1'b1, "R8 partial sets flag", rd, 1);
    acc(1, 3'd1, 0, 32'h01, rd, lat);

    // R11 R7 stall while busy
    acc(1, 3'd2, 0, 32'h04, rd, lat);
    clearLog(3, -1);
    begin
      int busyCnt, rvBusy;
      busyCnt = 0; rvBusy = 0;
      @(negedge clk);
      hostReq = 1; hostWrite = 1; hostAddr = 3'd4; hostSize = 2'd2; hostWdata = 32'h0102_0304;
      @(negedge clk);
      hostWrite = 0; hostAddr = 3'd1; hostSize = 0;
      while (hostBusy && busyCnt < 100) begin
        busyCnt++;
        if (hostRvalid) rvBusy++;
        @(negedge clk);
      end
      @(negedge clk);
      hostReq = 0;
      chk(busyCnt == 19, "R11 R7 busy span", busyCnt, 19);
      chk(rvBusy == 0, "R11 no response while busy", rvBusy, 0);
      chk(hostRvalid && hostRdata == 32'hA6, "R11 stalled read served", hostRdata, 32'hA6);
      chk(logCnt == 4 && logData[3] == 8'h01, "R11 transfer complete", logCnt, 4);
    end

    summary();
  end

endmodule